// File: doc/BRIEF.md
# Binary Extension Field Inverter

This block computes the multiplicative inverse of an element of GF(2^n), where the field is chosen per operation by a reducing polynomial and its degree (1 to 64). An operation is issued with a one-cycle request carrying the operand, the polynomial and the degree. The unit then runs a shift-and-XOR extended-Euclid iteration over GF(2), one step per clock, and presents the inverse together with a one-cycle completion pulse.

Because every non-zero field element is invertible, there is no remainder or quotient output, and subtraction is the same XOR as addition. A zero operand is not treated as an error: it yields zero, which is what byte-substitution tables for block ciphers expect. One instance works on one operation at a time. It takes a new request once the previous one has completed.

Top module: `gfinv`

## Requirements
- R1: After reset, done_o and busy_o are low and result_o is zero.
- R2: A start_i pulse while busy_o is low is accepted. busy_o is high from the next cycle until the cycle after the done_o pulse.
- R3: For a non-zero reduced operand a, the result r satisfies r·a = 1 modulo poly_i. Here bit i of poly_i is the coefficient of x^i, bit degree_i is set, bit 0 is set, and the polynomial is irreducible.
- R4: A zero operand gives result_o equal to zero, with done_o high in the first cycle after the start is accepted.
- R5: When done_o is high, every result_o bit at or above degree_i (the binary degree captured at start) is zero.
- R6: done_o is high for exactly one cycle per accepted operation, and result_o holds its value until the next completion.
- R7: start_i is ignored while busy_o is high, including during the done_o cycle. The operation in flight keeps its captured operand and field.
- R8: done_o rises no later than 4·degree + 2 cycles after the start is accepted.
- R9: Back-to-back operations may each use a different polynomial and degree, from degree 1 up to degree 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| operand_i | input | 64 | Field element to invert, already reduced |
| poly_i | input | 65 | Reducing polynomial, bit i is the coefficient of x^i |
| degree_i | input | 7 | Degree of poly_i, 1 to 64 |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Inverse, valid with done_o and held afterwards |

## Verification
The completion of one operation and the arrival of a new request can fall in the same cycle. The bench provokes this by holding start_i high during the done_o cycle. It then checks that busy_o falls on the next cycle and that no further completion follows. The bench also pulses start_i with a different operand in the middle of a run, and it judges the result against the inverse of the original operand, using an independent shift-and-XOR field multiply.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
  localparam int unsigned MAX_DEG = 64;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
endpackage

// File: rtl/gfinv_halve.sv
// Divides a Bezout coefficient by x modulo f: adds f first when odd.
module gfinv_halve #(
  parameter int PW = 65
) (
  input  logic [PW-1:0] g_i,
  input  logic [PW-1:0] f_i,
  output logic [PW-1:0] h_o
);
  logic [PW-1:0] adj;
  always_comb begin
    adj = g_i[0] ? (g_i ^ f_i) : g_i;
    h_o = adj >> 1;
  end
endmodule

// File: rtl/gfinv_step.sv
// One iteration of the binary polynomial extended-Euclid reduction.
module gfinv_step #(
  parameter int PW = 65
) (
  input  logic [PW-1:0] u_i,
  input  logic [PW-1:0] v_i,
  input  logic [PW-1:0] g1_i,
  input  logic [PW-1:0] g2_i,
  input  logic [PW-1:0] f_i,
  output logic [PW-1:0] u_o,
  output logic [PW-1:0] v_o,
  output logic [PW-1:0] g1_o,
  output logic [PW-1:0] g2_o
);
  logic [PW-1:0] g1_half, g2_half;

  gfinv_halve #(.PW(PW)) u_h1 (.g_i(g1_i), .f_i(f_i), .h_o(g1_half));
  gfinv_halve #(.PW(PW)) u_h2 (.g_i(g2_i), .f_i(f_i), .h_o(g2_half));

  always_comb begin
    u_o  = u_i;
    v_o  = v_i;
    g1_o = g1_i;
    g2_o = g2_i;
    if (!u_i[0]) begin
      u_o  = u_i >> 1;
      g1_o = g1_half;
    end else if (!v_i[0]) begin
      v_o  = v_i >> 1;
      g2_o = g2_half;
    end else if (u_i > v_i) begin
      // numeric order implies degree order when degrees differ
      u_o  = u_i ^ v_i;
      g1_o = g1_i ^ g2_i;
    end else begin
      v_o  = v_i ^ u_i;
      g2_o = g2_i ^ g1_i;
    end
  end
endmodule

// File: rtl/gfinv_mask.sv
// Builds a mask of the bits strictly below the field degree.
module gfinv_mask #(
  parameter int W  = 64,
  parameter int DW = 7
) (
  input  logic [DW-1:0] deg_i,
  output logic [W-1:0]  mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask_o[i] = (32'(deg_i) > i);
  end
endmodule

// File: rtl/gfinv_fsm.sv
module gfinv_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              zero_i,
  input  logic              fin_i,
  output gfinv_pkg::st_e    state_o,
  output logic              accept_o
);
  import gfinv_pkg::*;
  st_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        state_d  = zero_i ? ST_DONE : ST_RUN;
      end
      ST_RUN:  if (fin_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/gfinv.sv
module gfinv #(
  parameter int W  = gfinv_pkg::MAX_DEG,
  parameter int PW = W + 1,
  parameter int DW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  operand_i,
  input  logic [W:0]    poly_i,
  input  logic [DW-1:0] degree_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  import gfinv_pkg::*;

  logic [PW-1:0] u_q, v_q, g1_q, g2_q, f_q;
  logic [PW-1:0] u_d, v_d, g1_d, g2_d;
  logic [DW-1:0] deg_q;
  logic          zero_q;
  logic [W-1:0]  res_q, mask;
  logic [PW-1:0] pick;
  logic          fin_u, fin_v, fin, accept, op_zero, step_en, fin_en;
  st_e           state;

  assign op_zero = (operand_i == '0);
  assign fin_u   = (u_q == PW'(1));
  assign fin_v   = (v_q == PW'(1));
  assign fin     = fin_u | fin_v;
  assign pick    = fin_u ? g1_q : g2_q;

  gfinv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_i(op_zero),
    .fin_i(fin), .state_o(state), .accept_o(accept)
  );

  gfinv_step #(.PW(PW)) u_step (
    .u_i(u_q), .v_i(v_q), .g1_i(g1_q), .g2_i(g2_q), .f_i(f_q),
    .u_o(u_d), .v_o(v_d), .g1_o(g1_d), .g2_o(g2_d)
  );

  gfinv_mask #(.W(W), .DW(DW)) u_mask (.deg_i(deg_q), .mask_o(mask));

  assign step_en = (state == ST_RUN) && !fin;
  assign fin_en  = (state == ST_RUN) && fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q    <= '0;
      v_q    <= '0;
      g1_q   <= '0;
      g2_q   <= '0;
      f_q    <= '0;
      deg_q  <= '0;
      zero_q <= 1'b0;
      res_q  <= '0;
    end else begin
      if (accept) begin
        u_q    <= {1'b0, operand_i};
        v_q    <= poly_i;
        g1_q   <= PW'(1);
        g2_q   <= '0;
        f_q    <= poly_i;
        deg_q  <= degree_i;
        zero_q <= op_zero;
        if (op_zero) res_q <= '0;
      end
      if (step_en) begin
        u_q  <= u_d;
        v_q  <= v_d;
        g1_q <= g1_d;
        g2_q <= g2_d;
      end
      if (fin_en) res_q <= pick[W-1:0] & mask;
    end
  end

  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_DONE);
  assign result_o = res_q;
endmodule

// File: rtl/gfinv_chk.sv
module gfinv_chk #(
  parameter int W  = 64,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  result_o,
  input logic [DW-1:0] deg_q,
  input logic          zero_q
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 16'd1;
    else             run_cnt <= '0;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R7
  done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R5
  high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((result_o >> deg_q) == '0));
  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_q) |-> (result_o == '0));
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |-> (32'(run_cnt) <= (32'(deg_q) << 2) + 32'd2));
endmodule

bind gfinv gfinv_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .deg_q(deg_q), .zero_q(zero_q)
);

// File: tb/sim_gfinv.sv
module sim_gfinv;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [63:0] operand_i;
  logic [64:0] poly_i;
  logic [6:0]  degree_i;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic prev_done = 1'b0;

  always #10 clk = ~clk;

  gfinv u0 (.*);

  localparam logic [64:0] P8  = 65'h11B;
  localparam logic [64:0] P16 = 65'h1100B;
  localparam logic [64:0] P64 = {1'b1, 64'h1B};

  function automatic logic [63:0] gfmul(input logic [63:0] a, input logic [63:0] b,
                                        input logic [64:0] p, input int deg);
    logic [64:0] x, acc;
    x = {1'b0, a};
    acc = '0;
    for (int i = 0; i < deg; i++) begin
      if (b[i]) acc ^= x;
      x = x << 1;
      if (x[deg]) x ^= p;
    end
    return acc[63:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-clock monitor of the completion pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done) check(1'b0, "R6", 64'(done_o), 64'd0);
      prev_done = done_o;
    end
  end

  // disturb: 0 none, 1 start with another operand mid-run, 2 start on done cycle
  task automatic run_op(input logic [63:0] a, input logic [64:0] p, input int deg,
                        input int disturb);
    int cyc;
    logic [63:0] exp_mask, prod;
    @(negedge clk);
    start_i = 1'b1; operand_i = a; poly_i = p; degree_i = 7'(deg);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2", 64'(busy_o), 64'd1);
    cyc = 1;
    while (!done_o && cyc <= 4 * deg + 4) begin
      if (disturb == 1 && cyc == 2) begin
        start_i = 1'b1; operand_i = a ^ 64'h1; poly_i = P16; degree_i = 7'd16;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(cyc <= 4 * deg + 2, "R8", 64'(cyc), 64'(4 * deg + 2));
    exp_mask = (deg == 64) ? '1 : ((64'd1 << deg) - 64'd1);
    if (a == '0) begin
      check(cyc == 1, "R4 latency", 64'(cyc), 64'd1);
      check(result_o == '0, "R4", result_o, 64'd0);
    end else begin
      prod = gfmul(result_o, a, p, deg);
      check(prod == 64'd1, disturb == 1 ? "R7 R3" : "R3 R9", prod, 64'd1);
    end
    check((result_o & ~exp_mask) == '0, "R5", result_o, result_o & exp_mask);
    if (disturb == 2) begin
      start_i = 1'b1; operand_i = 64'h3; poly_i = P8; degree_i = 7'd8;
    end
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R6", 64'(done_o), 64'd0);
    check(busy_o == 1'b0, "R7 R2", 64'(busy_o), 64'd0);
    if (disturb == 2) begin
      @(negedge clk);
      check(busy_o == 1'b0 && done_o == 1'b0, "R7", 64'(busy_o), 64'd0);
    end
  endtask

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; start_i = 1'b0; operand_i = '0; poly_i = '0; degree_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R1", {62'd0, busy_o, done_o}, 64'd0);
    check(result_o == '0, "R1", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 256; a++) run_op(64'(a), P8, 8, 0);
    run_op(64'h1, 65'h3, 1, 0);
    run_op(64'h0, 65'h3, 1, 0);
    for (int a = 1; a < 40; a++) run_op(64'(a * 1657), P16, 16, 0);
    run_op(64'h1, P64, 64, 0);
    run_op(64'h2, P64, 64, 0);
    run_op(64'h8000_0000_0000_0000, P64, 64, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, P64, 64, 0);
    run_op(64'hDEAD_BEEF_0123_4567, P64, 64, 0);
    run_op(64'h0, P64, 64, 0);
    // back-to-back field changes
    run_op(64'h53, P8, 8, 0);
    run_op(64'h1234_5678_9ABC_DEF0, P64, 64, 0);
    run_op(64'hCA, P8, 8, 0);
    // mid-run start ignored
    run_op(64'h57, P8, 8, 1);
    run_op(64'h0F0F_0F0F_0F0F_0F0F, P64, 64, 1);
    // start coinciding with completion
    run_op(64'h8E, P8, 8, 2);
    held = result_o;
    repeat (3) @(negedge clk);
    check(result_o == held, "R6 hold", result_o, held);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule